// File: doc/BRIEF.md
# Transmit/Receive Word Queue Pair with Masked Interrupt Status

This block sits between a register interface and a serial shift engine. It holds two word queues, each 16 entries of 32 bits. Register-side software puts outgoing words into the transmit queue and takes incoming words out of the receive queue. The shift engine drains the transmit queue, fills the receive queue, and raises a one-cycle pulse when a transfer finishes.

Eight status flags describe the queues and the completion event. Each flag has its own enable bit, and the single interrupt line is raised when any flag is set together with its enable bit. The flags cover emptiness, fill level, the half-full threshold, receive overrun and transfer completion. Software can also read both occupancy counts as one word, and can flush each queue on its own.

Data moves through valid/ready handshakes, with the following back-pressure rules:
- **Register write into the transmit queue:** accepted only in a cycle where `tx_in_valid` and `tx_in_ready` are both high. `tx_in_ready` is low while the queue is full.
- **Register read from the receive queue:** the head word is consumed in a cycle where `rx_out_valid` and `rx_out_ready` are both high.
- **Engine read from the transmit queue:** the head word is consumed in a cycle where `core_tx_valid` and `core_tx_ready` are both high.
- **Engine push into the receive queue:** this path has no ready signal. A word pushed while the receive queue is full is lost and recorded as an overrun.

Top module: `xfi_top`

## Requirements
- R1: Status bit layout, which the enable input uses too: bit 0 TX empty, bit 1 TX half-full, bit 2 TX full, bit 3 RX not empty, bit 4 RX half-full, bit 5 RX full, bit 6 RX overrun, bit 7 transfer complete. After reset the status reads 8'h01.
- R2: Each queue holds up to 16 words and returns them in the order they were written.
- R3: While the TX queue holds 16 words, `tx_in_ready` is low and a write leaves the count and the contents unchanged.
- R4: A half-full bit is 1 exactly when that queue holds 8 or more words.
- R5: `occupancy` carries the TX word count in bits 4:0 and the RX word count in bits 9:5.
- R6: An engine push while the RX queue is full drops the word and sets the overrun bit. The overrun bit stays set, even after reads, until an RX flush.
- R7: While the RX queue is empty, `rx_out_data` is 0, and asserting `rx_out_ready` leaves the count at 0.
- R8: `core_done` sets the complete bit. A status write with bit 7 = 1 clears it, and a write with bit 7 = 0 leaves it set. If a done pulse and a clearing write arrive in the same cycle, the bit stays set.
- R9: `irq` is a register. It is high in the cycle after any status bit and its enable bit are both 1, and low otherwise.
- R10: `tx_flush` empties only the TX queue. `rx_flush` empties only the RX queue and clears the overrun bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_in_valid | input | 1 | Register side offers a TX word |
| tx_in_ready | output | 1 | TX queue can accept a word |
| tx_in_data | input | 32 | TX word from the register side |
| rx_out_valid | output | 1 | RX queue holds a word |
| rx_out_ready | input | 1 | Register side takes the RX head word |
| rx_out_data | output | 32 | RX head word, or 0 when the queue is empty |
| core_tx_valid | output | 1 | TX queue holds a word for the engine |
| core_tx_ready | input | 1 | Engine takes the TX head word |
| core_tx_data | output | 32 | TX head word, or 0 when the queue is empty |
| core_rx_valid | input | 1 | Engine pushes a received word |
| core_rx_data | input | 32 | Received word |
| core_done | input | 1 | Transfer-complete pulse from the engine |
| irq_en | input | 8 | Per-flag interrupt enables, laid out as in R1 |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 8 | Status write data; bit 7 = 1 clears the complete bit |
| status | output | 8 | Status flags, laid out as in R1 |
| occupancy | output | 10 | Both queue counts, laid out as in R5 |
| tx_flush | input | 1 | Empty the TX queue |
| rx_flush | input | 1 | Empty the RX queue and clear the overrun bit |
| irq | output | 1 | Interrupt line |

## Verification
A wrong pointer or count shows up at the ports within one cycle. `occupancy` drifts away from the number of accepted words, or a word comes out of a queue out of order. A half-full, full or empty flag that disagrees with the count is visible on `status` in the same cycle. A wrong enable mask, or a wrong sticky flag, reaches `irq` one cycle later. The directed scenarios therefore compare `status`, `occupancy`, the head data and `irq` after every single stimulus cycle, rather than only at the end of a sequence.

// File: rtl/xfi_pkg.sv
package xfi_pkg;
  localparam int ST_BITS = 8;
  localparam int ST_TXE  = 0;
  localparam int ST_TXH  = 1;
  localparam int ST_TXF  = 2;
  localparam int ST_RXR  = 3;
  localparam int ST_RXH  = 4;
  localparam int ST_RXF  = 5;
  localparam int ST_RXO  = 6;
  localparam int ST_CMP  = 7;
  typedef logic [ST_BITS-1:0] stat_t;
endpackage

// File: rtl/xfi_fifo.sv
module xfi_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty,
  output logic             drop
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign drop    = push && full && !flush;
  assign dout    = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  // R2: count never exceeds the depth
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R3/R6: a push into a full queue without a pop does not change the count
  assert_full_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> (count == CW'(DEPTH)));
  // R7: a pop from an empty queue without a push leaves it empty
  assert_empty_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push && !flush) |=> empty);
  // R10: a flush leaves the queue empty
  assert_flush_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
endmodule

// File: rtl/xfi_status.sv
module xfi_status
  import xfi_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int HALF = DEPTH / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] tx_cnt,
  input  logic [CW-1:0] rx_cnt,
  input  logic          rx_drop,
  input  logic          rx_flush,
  input  logic          done_evt,
  input  logic          clr_wr,
  input  stat_t         clr_data,
  input  stat_t         irq_en,
  output stat_t         stat,
  output logic          irq
);
  logic ovf_q, cmp_q, irq_q;
  logic [ST_BITS-2:0] unused_wbits;

  assign unused_wbits = clr_data[ST_BITS-2:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ovf_q <= 1'b0;
    else if (rx_flush)   ovf_q <= 1'b0;
    else if (rx_drop)    ovf_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             cmp_q <= 1'b0;
    else if (done_evt)                      cmp_q <= 1'b1;
    else if (clr_wr && clr_data[ST_CMP])    cmp_q <= 1'b0;
  end

  always_comb begin
    stat         = '0;
    stat[ST_TXE] = (tx_cnt == '0);
    stat[ST_TXH] = (tx_cnt >= CW'(HALF));
    stat[ST_TXF] = (tx_cnt == CW'(DEPTH));
    stat[ST_RXR] = (rx_cnt != '0);
    stat[ST_RXH] = (rx_cnt >= CW'(HALF));
    stat[ST_RXF] = (rx_cnt == CW'(DEPTH));
    stat[ST_RXO] = ovf_q;
    stat[ST_CMP] = cmp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(stat & irq_en);
  end
  assign irq = irq_q;

  // R8: a done pulse always leaves the complete bit set
  assert_done_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> stat[ST_CMP]);
  // R6: overrun is sticky until an RX flush
  assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[ST_RXO] && !rx_flush) |=> stat[ST_RXO]);
  // R6: overrun only rises after a dropped push
  assert_ovf_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[ST_RXO]) |-> $past(rx_drop));
  // R9: an enabled flag raises the line one cycle later
  assert_irq_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat & irq_en)) |=> irq);
  // R9: no enabled flag, no interrupt one cycle later
  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(stat & irq_en)) |=> !irq);
endmodule

// File: rtl/xfi_top.sv
module xfi_top
  import xfi_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_in_valid,
  output logic              tx_in_ready,
  input  logic [WIDTH-1:0]  tx_in_data,
  output logic              rx_out_valid,
  input  logic              rx_out_ready,
  output logic [WIDTH-1:0]  rx_out_data,
  output logic              core_tx_valid,
  input  logic              core_tx_ready,
  output logic [WIDTH-1:0]  core_tx_data,
  input  logic              core_rx_valid,
  input  logic [WIDTH-1:0]  core_rx_data,
  input  logic              core_done,
  input  logic [7:0]        irq_en,
  input  logic              stat_wr,
  input  logic [7:0]        stat_wdata,
  output logic [7:0]        status,
  output logic [2*CW-1:0]   occupancy,
  input  logic              tx_flush,
  input  logic              rx_flush,
  output logic              irq
);
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          tx_full, tx_empty, tx_drop_unused;
  logic          rx_full_unused, rx_empty, rx_drop;

  xfi_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_txq (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (tx_flush),
    .push  (tx_in_valid),
    .din   (tx_in_data),
    .pop   (core_tx_ready),
    .dout  (core_tx_data),
    .count (tx_cnt),
    .full  (tx_full),
    .empty (tx_empty),
    .drop  (tx_drop_unused)
  );

  xfi_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_rxq (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (rx_flush),
    .push  (core_rx_valid),
    .din   (core_rx_data),
    .pop   (rx_out_ready),
    .dout  (rx_out_data),
    .count (rx_cnt),
    .full  (rx_full_unused),
    .empty (rx_empty),
    .drop  (rx_drop)
  );

  assign tx_in_ready   = !tx_full;
  assign core_tx_valid = !tx_empty;
  assign rx_out_valid  = !rx_empty;
  assign occupancy     = {rx_cnt, tx_cnt};

  xfi_status #(.DEPTH(DEPTH)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_cnt   (tx_cnt),
    .rx_cnt   (rx_cnt),
    .rx_drop  (rx_drop),
    .rx_flush (rx_flush),
    .done_evt (core_done),
    .clr_wr   (stat_wr),
    .clr_data (stat_wdata),
    .irq_en   (irq_en),
    .stat     (status),
    .irq      (irq)
  );

  // R5: occupancy follows accepted TX writes one cycle later
  assert_tx_occ_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_in_valid && tx_in_ready && !core_tx_ready && !tx_flush)
      |=> (occupancy[CW-1:0] == $past(occupancy[CW-1:0]) + CW'(1)));
  // R3: ready stays low while full and nothing leaves
  assert_tx_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_in_ready && !core_tx_ready && !tx_flush) |=> !tx_in_ready);
endmodule

// File: tb/sim_xfi_top.sv
`timescale 1ns/1ps
module sim_xfi_top;
  localparam int W = 32;
  localparam int D = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_in_valid = 0, rx_out_ready = 0, core_tx_ready = 0, core_rx_valid = 0;
  logic core_done = 0, stat_wr = 0, tx_flush = 0, rx_flush = 0;
  logic [W-1:0] tx_in_data = '0, core_rx_data = '0;
  logic [7:0] irq_en = '0, stat_wdata = '0;
  logic tx_in_ready, rx_out_valid, core_tx_valid, irq;
  logic [W-1:0] rx_out_data, core_tx_data;
  logic [7:0] status;
  logic [9:0] occupancy;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  xfi_top u0 (
    .clk(clk), .rst_n(rst_n),
    .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready), .tx_in_data(tx_in_data),
    .rx_out_valid(rx_out_valid), .rx_out_ready(rx_out_ready), .rx_out_data(rx_out_data),
    .core_tx_valid(core_tx_valid), .core_tx_ready(core_tx_ready), .core_tx_data(core_tx_data),
    .core_rx_valid(core_rx_valid), .core_rx_data(core_rx_data),
    .core_done(core_done), .irq_en(irq_en), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .status(status), .occupancy(occupancy),
    .tx_flush(tx_flush), .rx_flush(rx_flush), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_tx(input logic [31:0] w);
    @(negedge clk); tx_in_valid = 1; tx_in_data = w;
    @(negedge clk); tx_in_valid = 0;
  endtask

  task automatic push_rx(input logic [31:0] w);
    @(negedge clk); core_rx_valid = 1; core_rx_data = w;
    @(negedge clk); core_rx_valid = 0;
  endtask

  task automatic pop_tx(output logic [31:0] w);
    @(negedge clk); w = core_tx_data; core_tx_ready = 1;
    @(negedge clk); core_tx_ready = 0;
  endtask

  task automatic rd_rx(output logic [31:0] w);
    @(negedge clk); w = rx_out_data; rx_out_ready = 1;
    @(negedge clk); rx_out_ready = 0;
  endtask

  task automatic pulse_flush(input logic t, input logic r);
    @(negedge clk); tx_flush = t; rx_flush = r;
    @(negedge clk); tx_flush = 0; rx_flush = 0;
  endtask

  task automatic t_reset();
    chk("R1 reset status", status, 8'h01);
    chk("R5 reset occupancy", occupancy, 0);
    chk("R9 reset irq", irq, 0);
    chk("R7 reset rx data", rx_out_data, 0);
  endtask

  task automatic t_tx_path();
    logic [31:0] w;
    for (int i = 0; i < 7; i++) wr_tx(32'hA000_0000 + i);
    chk("R4 tx 7 words not half", status[1], 0);
    wr_tx(32'hA000_0007);
    chk("R4 tx 8 words half", status[1], 1);
    for (int i = 8; i < D; i++) wr_tx(32'hA000_0000 + i);
    chk("R5 tx count 16", occupancy[4:0], 16);
    chk("R1 tx full flags", status[2:0], 3'b110);
    chk("R3 ready low when full", tx_in_ready, 0);
    wr_tx(32'hDEAD_BEEF);
    chk("R3 ignored write count", occupancy[4:0], 16);
    for (int i = 0; i < D; i++) begin
      pop_tx(w);
      chk("R2 tx order", w, 32'hA000_0000 + i);
    end
    chk("R3 extra word not stored", core_tx_valid, 0);
    chk("R1 tx empty again", status[2:0], 3'b001);
  endtask

  task automatic t_rx_path();
    logic [31:0] w;
    for (int i = 0; i < 7; i++) push_rx(32'hB100 + i);
    chk("R1 rx ready bit", status[3], 1);
    chk("R4 rx 7 not half", status[4], 0);
    push_rx(32'hB107);
    chk("R4 rx 8 half", status[4], 1);
    chk("R5 rx count field", occupancy, {5'd8, 5'd0});
    for (int i = 0; i < 8; i++) begin
      rd_rx(w);
      chk("R2 rx order", w, 32'hB100 + i);
    end
    chk("R7 empty data zero", rx_out_data, 0);
    rd_rx(w);
    chk("R7 empty read value", w, 0);
    chk("R7 empty read count", occupancy[9:5], 0);
    chk("R7 empty valid low", rx_out_valid, 0);
  endtask

  task automatic t_overrun();
    logic [31:0] w;
    for (int i = 0; i < D; i++) push_rx(32'hC000 + i);
    chk("R6 no overrun at 16", status[6], 0);
    chk("R1 rx full bit", status[5], 1);
    push_rx(32'hFFFF_0000);
    chk("R6 overrun set", status[6], 1);
    chk("R6 count stays 16", occupancy[9:5], 16);
    rd_rx(w);
    chk("R6 head kept", w, 32'hC000);
    chk("R6 overrun sticky after read", status[6], 1);
    pulse_flush(0, 1);
    chk("R10 rx flush count", occupancy[9:5], 0);
    chk("R10 rx flush clears overrun", status[6], 0);
    push_rx(32'h1234);
    rd_rx(w);
    chk("R10 rx usable after flush", w, 32'h1234);
  endtask

  task automatic t_flush_indep();
    for (int i = 0; i < 3; i++) wr_tx(32'h10 + i);
    for (int i = 0; i < 2; i++) push_rx(32'h20 + i);
    pulse_flush(1, 0);
    chk("R10 tx flush empties tx", occupancy[4:0], 0);
    chk("R10 tx flush keeps rx", occupancy[9:5], 2);
    chk("R10 rx head intact", rx_out_data, 32'h20);
    pulse_flush(0, 1);
    chk("R10 rx flushed", occupancy, 0);
  endtask

  task automatic t_complete();
    irq_en = 8'h80;
    @(negedge clk); core_done = 1;
    @(negedge clk); core_done = 0;
    chk("R8 done sets bit7", status[7], 1);
    @(negedge clk);
    chk("R9 irq on complete", irq, 1);
    @(negedge clk); stat_wr = 1; stat_wdata = 8'h7F;
    @(negedge clk); stat_wr = 0;
    chk("R8 write bit7=0 keeps", status[7], 1);
    @(negedge clk); stat_wr = 1; stat_wdata = 8'h80; core_done = 1;
    @(negedge clk); stat_wr = 0; core_done = 0;
    chk("R8 set wins over clear", status[7], 1);
    @(negedge clk); stat_wr = 1; stat_wdata = 8'h80;
    @(negedge clk); stat_wr = 0;
    chk("R8 clear", status[7], 0);
    @(negedge clk);
    chk("R9 irq drops", irq, 0);
  endtask

  task automatic t_mask();
    irq_en = 8'h00;
    repeat (2) @(negedge clk);
    chk("R9 masked tx empty", irq, 0);
    irq_en = 8'h01;
    @(negedge clk);
    chk("R9 enabled tx empty", irq, 1);
    irq_en = 8'h7E;
    @(negedge clk);
    chk("R9 other enables idle", irq, 0);
    irq_en = 8'h00;
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_tx_path();
    t_rx_path();
    t_overrun();
    t_flush_indep();
    t_complete();
    t_mask();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule